// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block derives a slower serial-port clock from a fast input clock. Software writes one 6-bit value; the block divides the input clock by half that value, so the divisor runs from 0 to 31.5 in steps of one half. Half-integer ratios need both input clock edges, so the output is built from a rising-edge flop and a falling-edge flop that each own one kind of output transition.

The output waveform is not square. Its low phase has a fixed length that depends on the divisor range. Short divisors get a short low phase. Long divisors get a four-cycle low phase, plus a half cycle when the ratio is a half-integer. This keeps both output phases wide enough for a downstream receiver/transmitter that has minimum pulse-width limits.

Every write to the divisor restarts the divider from a known phase. Each write also sends a short reset pulse to the downstream serial logic, so that logic never sees a torn clock pattern.

Top module: `halfstep_clk_div`

## Requirements
- R1: For a stored value v of 4 or more, the output period is exactly v half-cycles of the input clock, so the division ratio is v/2 and bit 0 of v is the half step.
- R2: For even v from 4 to 14 (ratios 2 to 7), the output is low for 2 input half-cycles (one input cycle) in each period.
- R3: For odd v from 5 to 15 (ratios 2.5 to 7.5), the output is low for 3 input half-cycles in each period.
- R4: For even v from 16 to 62 (ratios 8 to 31), the output is low for 8 input half-cycles (four input cycles) in each period.
- R5: For odd v from 17 to 63 (ratios 8.5 to 31.5), the output is low for 9 input half-cycles in each period.
- R6: For v from 0 to 3, the divider is stopped and the output stays low.
- R7: A write is taken on the rising input edge where `wr_en` is high. The output is low from that edge on. The first period under the new value starts at the next rising edge, beginning with its low phase.
- R8: `uart_rst` goes high at the rising edge that takes a write and stays high for exactly 2 input cycles. It is never high without a write.
- R9: After reset, the output and `uart_rst` are low and the stored value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; both edges are used |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Divisor write strobe, sampled on the rising edge |
| wr_data | input | 6 | Divisor in half steps (ratio = wr_data/2) |
| clk_out | output | 1 | Divided clock |
| uart_rst | output | 1 | Reset pulse to the downstream serial logic after each write |

## Verification
The bench writes every one of the 64 possible divisor values in turn, with no idle gap between writes, so each write also restarts a running divider. It samples the output in the middle of every input half-cycle and compares it with a waveform computed from the period and low-time rules. Even and odd values show whether the falling-edge half steps are placed correctly. Values on either side of 4 and of 16 show the stop range and the switch between the short and long low phases. The reset pulse is checked on the write edge, on the edge after it, and on the edge where it must drop.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;
   // Low-phase length in input half-cycles, chosen by divisor range.
   function automatic int unsigned low_halves(int unsigned v, int unsigned short_low,
                                              int unsigned long_low, int unsigned long_min);
      int unsigned base;
      base = (v >= long_min) ? long_low : short_low;
      return base + (v % 2);
   endfunction
endpackage

// File: rtl/hsdiv_cfg.sv
module hsdiv_cfg #(
   parameter int DIV_W      = 6,
   parameter int RST_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W-1:0] wr_data,
   output logic [DIV_W-1:0] div_q,
   output logic             uart_rst
);
   localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     div_q <= '0;
      else if (wr_en) div_q <= wr_data;
   end

   generate
      if (RST_CYCLES == 1) begin : g_pulse_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) uart_rst <= 1'b0;
            else        uart_rst <= wr_en;
         end
      end else begin : g_pulse_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (wr_en)          cnt_q <= CNT_W'(RST_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign uart_rst = (cnt_q != '0);
      end
   endgenerate

   assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> uart_rst);
   assert_rst_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uart_rst) |-> $past(wr_en));
endmodule

// File: rtl/hsdiv_phase.sv
module hsdiv_phase
   import hsdiv_pkg::*;
#(
   parameter int DIV_W     = 6,
   parameter int MIN_RUN   = 4,
   parameter int SHORT_LOW = 2,
   parameter int LONG_LOW  = 8,
   parameter int LONG_MIN  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             run,
   output logic             lvl_now,
   output logic             lvl_next
);
   localparam int IW = DIV_W + 1;

   logic [IW-1:0] h_q, h1, h2, div_w, low_len;

   assign div_w   = IW'(div);
   assign run     = (int'(div) >= MIN_RUN);
   assign low_len = IW'(low_halves(int'(div), SHORT_LOW, LONG_LOW, LONG_MIN));
   assign h1      = (h_q + 1 >= div_w) ? h_q + 1 - div_w : h_q + 1;
   assign h2      = (h_q + 2 >= div_w) ? h_q + 2 - div_w : h_q + 2;

   // Level of the half starting at this rising edge and of the following half.
   assign lvl_now  = run && (h_q >= low_len);
   assign lvl_next = run && (h1  >= low_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                h_q <= '0;
      else if (restart || !run)  h_q <= '0;
      else                       h_q <= h2;
   end

   assert_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (h_q < div_w));
endmodule

// File: rtl/hsdiv_edge_out.sv
module hsdiv_edge_out (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic lvl_now,
   input  logic lvl_next,
   output logic clk_out
);
   logic p_q, n_q, want_n_q;

   // Rising-edge flop drives transitions at rising edges.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q      <= 1'b0;
         want_n_q <= 1'b0;
      end else if (restart) begin
         p_q      <= n_q;
         want_n_q <= 1'b0;
      end else begin
         p_q      <= n_q ^ lvl_now;
         want_n_q <= lvl_next;
      end
   end

   // Falling-edge flop drives transitions at falling edges.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) n_q <= 1'b0;
      else        n_q <= p_q ^ want_n_q;
   end

   assign clk_out = p_q ^ n_q;
endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div #(
   parameter int DIV_W      = 6,
   parameter int RST_CYCLES = 2,
   parameter int MIN_RUN    = 4,
   parameter int SHORT_LOW  = 2,
   parameter int LONG_LOW   = 8,
   parameter int LONG_MIN   = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [5:0] wr_data,
   output logic       clk_out,
   output logic       uart_rst
);
   localparam int DIV_MAX = (1 << DIV_W) - 1;

   generate
      if (DIV_W != 6) begin : g_bad_width
         $error("DIV_W must match the 6-bit write port");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
      if (MIN_RUN <= SHORT_LOW + 1) begin : g_bad_min
         $error("MIN_RUN must leave a high phase for the shortest period");
      end
      if (LONG_MIN <= LONG_LOW + 1 || LONG_MIN > DIV_MAX) begin : g_bad_long
         $error("LONG_MIN must exceed the long low phase and fit in DIV_W");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             run, lvl_now, lvl_next;

   hsdiv_cfg #(.DIV_W(DIV_W), .RST_CYCLES(RST_CYCLES)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .div_q(div_q), .uart_rst(uart_rst)
   );

   hsdiv_phase #(.DIV_W(DIV_W), .MIN_RUN(MIN_RUN), .SHORT_LOW(SHORT_LOW),
                 .LONG_LOW(LONG_LOW), .LONG_MIN(LONG_MIN)) u_phase (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .div(div_q),
      .run(run), .lvl_now(lvl_now), .lvl_next(lvl_next)
   );

   hsdiv_edge_out u_out (
      .clk(clk), .rst_n(rst_n), .restart(wr_en),
      .lvl_now(lvl_now), .lvl_next(lvl_next), .clk_out(clk_out)
   );

   assert_stop_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(div_q) < MIN_RUN) |-> !clk_out);
   assert_restart_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !clk_out);
endmodule

// File: tb/halfstep_clk_div_tb.sv
`timescale 1ns/1ps
module halfstep_clk_div_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [5:0] wr_data = '0;
   logic clk_out, uart_rst;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   halfstep_clk_div u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .clk_out(clk_out), .uart_rst(uart_rst)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string req_of(input int v);
      if (v < 4)           return "R6";
      if (v < 16)          return (v % 2) ? "R3" : "R2";
      return (v % 2) ? "R5" : "R4";
   endfunction

   function automatic int low_len(input int v);
      return ((v >= 16) ? 8 : 2) + (v % 2);
   endfunction

   function automatic bit exp_level(input int v, input int j);
      if (v < 4) return 1'b0;
      return ((j % v) >= low_len(v));
   endfunction

   task automatic write_and_sweep(input int v);
      int n_halves, bad, first_bad_j, lows;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 6'(v);
      @(posedge clk);
      #1;
      check(uart_rst == 1'b1, "R8 pulse on write edge", uart_rst, 1);
      check(clk_out == 1'b0, "R7 low after write edge", clk_out, 0);
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk);
      #1.25;
      check(uart_rst == 1'b1, "R8 pulse second cycle", uart_rst, 1);
      n_halves = (v < 8) ? 24 : 3 * v;
      bad = 0;
      first_bad_j = -1;
      lows = 0;
      for (int j = 0; j < n_halves; j++) begin
         if (j == 2) check(uart_rst == 1'b0, "R8 pulse ends after 2 cycles", uart_rst, 0);
         if (clk_out !== exp_level(v, j)) begin
            if (first_bad_j < 0) first_bad_j = j;
            bad++;
         end
         if (v >= 4 && j >= v && j < 2 * v && clk_out == 1'b0) lows++;
         #2.5;
      end
      // R1 plus the per-range low-time rule: whole sampled waveform
      if (bad != 0)
         check(1'b0, {req_of(v), "/R1 waveform v=", $sformatf("%0d half=%0d", v, first_bad_j)},
               clk_out, exp_level(v, first_bad_j));
      else
         check(1'b1, "R1", 0, 0);
      if (v >= 4)
         check(lows == low_len(v), {req_of(v), " low halves per period"}, lows, low_len(v));
   endtask

   initial begin
      #3;
      check(clk_out == 1'b0, "R9 output low in reset", clk_out, 0);
      check(uart_rst == 1'b0, "R9 no pulse in reset", uart_rst, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (6) begin
         @(negedge clk);
         check(clk_out == 1'b0, "R9 stopped after reset", clk_out, 0);
         check(uart_rst == 1'b0, "R9 no pulse after reset", uart_rst, 0);
      end
      for (int v = 0; v < 64; v++) write_and_sweep(v);
      // restart from a long period back into short and stopped values
      write_and_sweep(5);
      write_and_sweep(63);
      write_and_sweep(2);
      write_and_sweep(4);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5ns * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule